// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic unit of a small accumulator processor. Each cycle it takes an operation code, a register operand (the accumulator or an index register), a memory operand and the carry held in its own flag register. It returns the result at once, without a register. It also returns a write indication that says whether the destination should take that result. On a clock edge with the load enable high, the four status flags (negative, overflow, zero, carry) are updated. Each operation touches only its own subset of flags.

Arithmetic covers add with carry, subtract with borrow and compare. The logic unit performs AND, OR, XOR, a memory load pass-through and a bit test; the bit test copies the top two bits of the memory operand straight into negative and overflow. The unary unit shifts, rotates through carry, increments and decrements the register operand; the memory operand has no effect on these. The caller routes a memory byte to `reg_i` when the target is memory. Operand fetch, addressing and decimal arithmetic live elsewhere.

Flags appear on `flags_o` as bit 3 = N, bit 2 = V, bit 1 = Z, bit 0 = C. Operation codes on `op_i`: 0 add, 1 subtract, 2 compare, 3 AND, 4 OR, 5 XOR, 6 bit test, 7 shift left, 8 shift right, 9 rotate left, 10 rotate right, 11 increment, 12 decrement, 13 load, 14 and 15 reserved.

Top module: `flag_alu`

## Requirements
- R1: While `rst_n` is low, all four flags read 0.
- R2: When `load_i` is low at a rising edge, `flags_o` keeps its value. Reserved codes 14 and 15 change no flag even with `load_i` high, give `res_o` = `reg_i` and `we_o` = 0.
- R3: Code 0 gives `res_o` = (reg + mem + C) mod 256. C is set to the carry out. V is set when reg and mem share a sign that the result does not. N is result bit 7 and Z is set when the result is zero.
- R4: Code 1 gives `res_o` = reg + (~mem) + C mod 256. C = 1 means no borrow. V follows the rule of R3 with ~mem as the second operand. N and Z follow the result.
- R5: Code 2 leaves the destination alone (`we_o` = 0, `res_o` = `reg_i`). It sets C when reg ≥ mem unsigned, Z when they are equal, and N to bit 7 of (reg − mem). V is unchanged.
- R6: Codes 3, 4, 5 and 13 give reg AND mem, reg OR mem, reg XOR mem and mem respectively. They update only N (bit 7) and Z.
- R7: Code 6 sets N to mem bit 7, V to mem bit 6 and Z to ((reg AND mem) == 0), and leaves C unchanged. It does not write (`we_o` = 0, `res_o` = `reg_i`).
- R8: Code 7 shifts reg left, filling with 0; old bit 7 goes to C. Code 8 shifts reg right, filling with 0; old bit 0 goes to C and N becomes 0. Both update N, Z and C and leave V unchanged.
- R9: Code 9 rotates reg left through carry: old C goes into bit 0 and old bit 7 goes to C. Code 10 rotates reg right through carry: old C goes into bit 7 and old bit 0 goes to C. Both update N, Z and C and leave V unchanged.
- R10: Codes 11 and 12 give reg + 1 and reg − 1 mod 256. They update only N and Z; C and V never change. `mem_i` has no effect on any of codes 7 to 12.
- R11: `we_o` is 1 for codes 0, 1, 3, 4, 5 and 7 to 13, and 0 for codes 2, 6, 14 and 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Operation code |
| reg_i | input | 8 | Register operand (accumulator or index) |
| mem_i | input | 8 | Memory operand |
| load_i | input | 1 | Flag register load enable |
| res_o | output | 8 | Result, combinational |
| we_o | output | 1 | Destination write indication |
| flags_o | output | 4 | Flags {N, V, Z, C} |

## Verification
The carry held in the flag register feeds the add, subtract and rotate operations. A wrong stored carry therefore shows up in `res_o` in the very next cycle that uses one of them, not only on `flags_o`. A wrong update mask, such as an increment that touches C or a bit test that writes C, appears on `flags_o` one edge after the operation. It then spreads into later results through the carry. Checking every cycle's result against a model that keeps its own flags catches such a fault within a few operations of random traffic.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_CMP = 4'd2,
    OP_AND = 4'd3,
    OP_OR  = 4'd4,
    OP_XOR = 4'd5,
    OP_BIT = 4'd6,
    OP_SHL = 4'd7,
    OP_SHR = 4'd8,
    OP_RL  = 4'd9,
    OP_RR  = 4'd10,
    OP_INC = 4'd11,
    OP_DEC = 4'd12,
    OP_LD  = 4'd13,
    OP_RS0 = 4'd14,
    OP_RS1 = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic v;
    logic z;
    logic c;
  } alu_flags_t;

  // Which flags an operation is allowed to write.
  function automatic alu_flags_t upd_mask(alu_op_e op);
    alu_flags_t m;
    m = '0;
    unique case (op)
      OP_ADD, OP_SUB:                 m = '{n: 1'b1, v: 1'b1, z: 1'b1, c: 1'b1};
      OP_CMP, OP_SHL, OP_SHR,
      OP_RL, OP_RR:                   m = '{n: 1'b1, v: 1'b0, z: 1'b1, c: 1'b1};
      OP_AND, OP_OR, OP_XOR,
      OP_LD, OP_INC, OP_DEC:          m = '{n: 1'b1, v: 1'b0, z: 1'b1, c: 1'b0};
      OP_BIT:                         m = '{n: 1'b1, v: 1'b1, z: 1'b1, c: 1'b0};
      default:                        m = '0;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/flag_alu_arith.sv
module flag_alu_arith
  import flag_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  alu_op_e            op,
  input  logic [WIDTH-1:0]   a,
  input  logic [WIDTH-1:0]   b,
  input  logic               cin,
  output logic [WIDTH-1:0]   res,
  output alu_flags_t         fl
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;
  logic             c_eff;
  logic [WIDTH:0]   sum;

  // Subtract and compare add the inverted operand; compare ignores the carry.
  always_comb begin
    b_eff = (op == OP_ADD) ? b : ~b;
    c_eff = (op == OP_CMP) ? 1'b1 : cin;
    sum   = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, c_eff};
  end

  always_comb begin
    res  = sum[MSB:0];
    fl.c = sum[WIDTH];
    fl.n = sum[MSB];
    fl.z = (sum[MSB:0] == '0);
    fl.v = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
  end

endmodule

// File: rtl/flag_alu_logic.sv
module flag_alu_logic
  import flag_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  alu_op_e            op,
  input  logic [WIDTH-1:0]   a,
  input  logic [WIDTH-1:0]   b,
  output logic [WIDTH-1:0]   res,
  output alu_flags_t         fl
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] conj;

  always_comb begin
    conj = a & b;
    unique case (op)
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_LD:   res = b;
      OP_BIT:  res = a;
      default: res = conj;
    endcase
  end

  always_comb begin
    fl.c = 1'b0;
    if (op == OP_BIT) begin
      // Top operand bits go straight to N and V; Z comes from the masked test.
      fl.n = b[MSB];
      fl.v = b[MSB-1];
      fl.z = (conj == '0);
    end else begin
      fl.n = res[MSB];
      fl.v = 1'b0;
      fl.z = (res == '0);
    end
  end

endmodule

// File: rtl/flag_alu_unary.sv
module flag_alu_unary
  import flag_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  alu_op_e            op,
  input  logic [WIDTH-1:0]   a,
  input  logic               cin,
  output logic [WIDTH-1:0]   res,
  output alu_flags_t         fl
);

  localparam int MSB = WIDTH - 1;

  always_comb begin
    res  = a;
    fl.c = cin;
    unique case (op)
      OP_SHL: begin res = {a[MSB-1:0], 1'b0}; fl.c = a[MSB]; end
      OP_SHR: begin res = {1'b0, a[MSB:1]};   fl.c = a[0];   end
      OP_RL:  begin res = {a[MSB-1:0], cin};  fl.c = a[MSB]; end
      OP_RR:  begin res = {cin, a[MSB:1]};    fl.c = a[0];   end
      OP_INC: res = a + {{(WIDTH-1){1'b0}}, 1'b1};
      OP_DEC: res = a - {{(WIDTH-1){1'b0}}, 1'b1};
      default: res = a;
    endcase
    fl.n = res[MSB];
    fl.z = (res == '0);
    fl.v = 1'b0;
  end

endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OP_W-1:0]   op_i,
  input  logic [WIDTH-1:0]  reg_i,
  input  logic [WIDTH-1:0]  mem_i,
  input  logic              load_i,
  output logic [WIDTH-1:0]  res_o,
  output logic              we_o,
  output logic [3:0]        flags_o
);

  alu_op_e          op;
  alu_flags_t       flags_q, flags_d, fl_new, mask;
  alu_flags_t       fl_ar, fl_lg, fl_un;
  logic [WIDTH-1:0] res_ar, res_lg, res_un;

  assign op = alu_op_e'(op_i);

  flag_alu_arith #(.WIDTH(WIDTH)) u_arith (
    .op(op), .a(reg_i), .b(mem_i), .cin(flags_q.c), .res(res_ar), .fl(fl_ar)
  );

  flag_alu_logic #(.WIDTH(WIDTH)) u_logic (
    .op(op), .a(reg_i), .b(mem_i), .res(res_lg), .fl(fl_lg)
  );

  flag_alu_unary #(.WIDTH(WIDTH)) u_unary (
    .op(op), .a(reg_i), .cin(flags_q.c), .res(res_un), .fl(fl_un)
  );

  // Result and write steering per operation group.
  always_comb begin
    res_o  = reg_i;
    we_o   = 1'b0;
    fl_new = flags_q;
    unique case (op)
      OP_ADD, OP_SUB: begin res_o = res_ar; we_o = 1'b1; fl_new = fl_ar; end
      OP_CMP:         begin fl_new = fl_ar; end
      OP_AND, OP_OR, OP_XOR, OP_LD:
                      begin res_o = res_lg; we_o = 1'b1; fl_new = fl_lg; end
      OP_BIT:         begin fl_new = fl_lg; end
      OP_SHL, OP_SHR, OP_RL, OP_RR, OP_INC, OP_DEC:
                      begin res_o = res_un; we_o = 1'b1; fl_new = fl_un; end
      default:        begin res_o = reg_i; we_o = 1'b0; end
    endcase
  end

  // Flag next state: load enable, then per-flag mask.
  always_comb begin
    mask    = upd_mask(op);
    flags_d = flags_q;
    if (load_i) begin
      if (mask.n) flags_d.n = fl_new.n;
      if (mask.v) flags_d.v = fl_new.v;
      if (mask.z) flags_d.z = fl_new.z;
      if (mask.c) flags_d.c = fl_new.c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign flags_o = flags_q;

endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk
  import flag_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [OP_W-1:0]   op_i,
  input logic [WIDTH-1:0]  reg_i,
  input logic [WIDTH-1:0]  mem_i,
  input logic              load_i,
  input logic [WIDTH-1:0]  res_o,
  input logic              we_o,
  input logic [3:0]        flags_o
);

  // R2
  hold_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(flags_o));

  // R10
  incdec_cv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && (op_i == OP_INC || op_i == OP_DEC)) |=> ($stable(flags_o[2]) && $stable(flags_o[0])));

  // R7
  bit_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && op_i == OP_BIT) |=> (flags_o[3:2] == $past(mem_i[WIDTH-1:WIDTH-2])));

  // R8
  shr_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && op_i == OP_SHR) |=> !flags_o[3]);

  // R5
  cmp_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_CMP) |-> (!we_o && res_o == reg_i));

  // R6
  zero_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && we_o) |=> (flags_o[1] == ($past(res_o) == '0)));

endmodule

bind flag_alu flag_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_i(op_i), .reg_i(reg_i), .mem_i(mem_i),
  .load_i(load_i), .res_o(res_o), .we_o(we_o), .flags_o(flags_o)
);

// File: tb/flag_alu_bench.sv
`timescale 1ns/1ps
module flag_alu_bench;

  logic       clk;
  logic       rst_n;
  logic [3:0] op_i;
  logic [7:0] reg_i, mem_i;
  logic       load_i;
  logic [7:0] res_o;
  logic       we_o;
  logic [3:0] flags_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  logic [3:0] mfl;   // model flags {N,V,Z,C}

  flag_alu u_flag_alu (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .reg_i(reg_i), .mem_i(mem_i),
    .load_i(load_i), .res_o(res_o), .we_o(we_o), .flags_o(flags_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'd0: return "R3";
      4'd1: return "R4";
      4'd2: return "R5";
      4'd3, 4'd4, 4'd5, 4'd13: return "R6";
      4'd6: return "R7";
      4'd7, 4'd8: return "R8";
      4'd9, 4'd10: return "R9";
      4'd11, 4'd12: return "R10";
      default: return "R2";
    endcase
  endfunction

  // Returns {we, result, new flags}; unchanged flags carry through.
  function automatic logic [12:0] model(input logic [3:0] op, input logic [7:0] r,
                                        input logic [7:0] m, input logic [3:0] f);
    int unsigned s;
    logic [7:0] q;
    logic n, v, z, c, we;
    n = f[3]; v = f[2]; z = f[1]; c = f[0];
    q = r; we = 1'b1;
    case (op)
      4'd0: begin s = r + m + c; q = s[7:0]; c = (s > 255);
                  v = (r[7] == m[7]) && (q[7] != r[7]); n = q[7]; z = (q == 0); end
      4'd1: begin s = r + (8'hFF ^ m) + c; q = s[7:0]; c = (s > 255);
                  v = (r[7] != m[7]) && (q[7] != r[7]); n = q[7]; z = (q == 0); end
      4'd2: begin q = r - m; c = (r >= m); z = (r == m); n = q[7]; q = r; we = 1'b0; end
      4'd3: begin q = r & m; n = q[7]; z = (q == 0); end
      4'd4: begin q = r | m; n = q[7]; z = (q == 0); end
      4'd5: begin q = r ^ m; n = q[7]; z = (q == 0); end
      4'd13: begin q = m; n = q[7]; z = (q == 0); end
      4'd6: begin n = m[7]; v = m[6]; z = ((r & m) == 0); we = 1'b0; end
      4'd7: begin q = r << 1; c = r[7]; n = q[7]; z = (q == 0); end
      4'd8: begin q = r >> 1; c = r[0]; n = 1'b0; z = (q == 0); end
      4'd9: begin q = {r[6:0], f[0]}; c = r[7]; n = q[7]; z = (q == 0); end
      4'd10: begin q = {f[0], r[7:1]}; c = r[0]; n = q[7]; z = (q == 0); end
      4'd11: begin q = r + 8'd1; n = q[7]; z = (q == 0); end
      4'd12: begin q = r - 8'd1; n = q[7]; z = (q == 0); end
      default: we = 1'b0;
    endcase
    return {we, q, n, v, z, c};
  endfunction

  task automatic step(input logic [3:0] op, input logic [7:0] r,
                      input logic [7:0] m, input logic ld);
    logic [12:0] e;
    @(negedge clk);
    op_i = op; reg_i = r; mem_i = m; load_i = ld;
    #1;
    e = model(op, r, m, mfl);
    total++;
    if (res_o !== e[11:4]) begin
      bad++;
      $display("FAIL %s result op=%0d r=%h m=%h actual=%h expected=%h",
               tag_of(op), op, r, m, res_o, e[11:4]);
    end
    total++;
    if (we_o !== e[12]) begin
      bad++;
      $display("FAIL R11 write op=%0d actual=%b expected=%b", op, we_o, e[12]);
    end
    @(posedge clk);
    #1;
    if (ld) mfl = e[3:0];
    total++;
    if (flags_o !== mfl) begin
      bad++;
      $display("FAIL %s flags op=%0d r=%h m=%h ld=%b actual=%b expected=%b",
               ld ? tag_of(op) : "R2", op, r, m, ld, flags_o, mfl);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    op_i = '0; reg_i = '0; mem_i = '0; load_i = 1'b0;
    rst_n = 1'b0;
    mfl = 4'b0000;
    repeat (3) @(posedge clk);
    #1;
    total++;
    if (flags_o !== 4'b0000) begin
      bad++;
      $display("FAIL R1 reset flags actual=%b expected=0000", flags_o);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // Directed corners
    step(4'd8,  8'h00, 8'h55, 1'b1);  // R8: C cleared, Z set
    step(4'd0,  8'h7F, 8'h01, 1'b1);  // R3: signed overflow
    step(4'd0,  8'hFF, 8'h01, 1'b1);  // R3: carry out, zero
    step(4'd0,  8'h00, 8'h00, 1'b1);  // R3: carry in adds one
    step(4'd1,  8'h00, 8'h01, 1'b1);  // R4: borrow
    step(4'd1,  8'h80, 8'h01, 1'b1);  // R4: overflow on subtract
    step(4'd2,  8'h40, 8'h40, 1'b1);  // R5: equal
    step(4'd2,  8'h10, 8'h20, 1'b1);  // R5: below
    step(4'd6,  8'h0F, 8'hC0, 1'b1);  // R7: copies top bits, Z set
    step(4'd6,  8'hFF, 8'h01, 1'b1);  // R7: N,V cleared
    step(4'd7,  8'h80, 8'hAA, 1'b1);  // R8: carry from bit 7
    step(4'd10, 8'h01, 8'h00, 1'b1);  // R9: carry into bit 7
    step(4'd9,  8'h80, 8'h00, 1'b1);  // R9: rotate left
    step(4'd11, 8'hFF, 8'h12, 1'b1);  // R10: wraps to zero, C kept
    step(4'd12, 8'h00, 8'h34, 1'b1);  // R10: wraps to FF
    step(4'd13, 8'h00, 8'h80, 1'b1);  // R6: load negative
    step(4'd5,  8'hA5, 8'hA5, 1'b1);  // R6: xor to zero
    step(4'd14, 8'h00, 8'h00, 1'b1);  // R2: reserved changes nothing
    step(4'd15, 8'h3C, 8'hFF, 1'b1);  // R2
    step(4'd0,  8'h00, 8'h00, 1'b0);  // R2: flags held without load

    // Random traffic
    for (int i = 0; i < 20000; i++) begin
      step(4'($urandom_range(0, 15)), 8'($urandom), 8'($urandom),
           ($urandom_range(0, 7) != 0));
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule